// File: doc/BRIEF.md
# Pulse-Swallow Programmable Frequency Divider

This block divides a fast clock by an integer ratio chosen at run time, the job it does in the feedback path of an integer-N synthesizer. A dual-modulus prescaler divides the fast clock by 3 or by 2. A swallow counter counts prescaler output pulses and steers the prescaler's modulus. A fixed program counter counts all prescaler output pulses modulo 8 and restarts the whole cycle. With the default parameters the ratio is 2·8 + S, so the 3-bit swallow word S gives ratios 16 to 23. The rule holds because the program counter modulus (8) is larger than any swallow value.

Everything runs on the fast clock. The prescaler output is used as a clock enable for the counters and is never used as a clock. The block drives a divided clock that is high for the first half of each period, the modulus-control level, and a one-cycle pulse that marks each period boundary. The swallow word is taken in only at a period boundary, so every output period has a single ratio.

Top module: `swallow_clk_div`

## Requirements
- R1: The number of fast-clock cycles between two consecutive `period_end_o` pulses equals 16 + S, where S is the swallow word in effect for that period, for every S from 0 to 7.
- R2: The prescaler divides by 3 while `mod_ctrl_o` is 0 and by 2 while it is 1. Within each period, `mod_ctrl_o` is 1 for exactly 2·(8 − S) fast-clock cycles.
- R3: When S is not 0, `mod_ctrl_o` is 0 in the first cycle of the period. Once it has risen, it stays 1 until the next period begins. When S = 0, it is 1 for the whole period.
- R4: `swallow_i` is sampled only on the clock edge that starts a new period. A change during a period does not affect that period's length, duty or modulus-control pattern.
- R5: `div_clk_o` is 1 for the first floor((16 + S)/2) cycles of each period, starting with the cycle in which `period_end_o` is 1, and 0 for the remaining cycles.
- R6: `period_end_o` is 1 for exactly one cycle per period: the first cycle of the new period, right after the last cycle of the old one.
- R7: `rst_ni` is an active-low asynchronous reset. While it is held, `div_clk_o` = 1, `mod_ctrl_o` = 1 and `period_end_o` = 0. The first period after release uses S = 0 whatever `swallow_i` is, so the first pulse comes 16 cycles after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| swallow_i | input | SW_W (3) | Swallow word S, sampled at each period boundary |
| div_clk_o | output | 1 | Divided clock, high for the first half of each period |
| mod_ctrl_o | output | 1 | Modulus control: 0 = prescaler divides by 3, 1 = divides by 2 |
| period_end_o | output | 1 | One-cycle pulse in the first cycle of each new period |

## Verification
The hardest case to reach from the ports is a swallow word that changes while a period is already running. The design must keep the old ratio for the rest of that period, and a bench that only changes S at period boundaries would never show a wrong sampling point. The stimulus therefore waits a few cycles past a boundary pulse, moves S from 2 to 7, and measures that period's length, duty and modulus pattern against the old value. It also asserts reset in the middle of a period while a nonzero S is applied, to show that the first period after release falls back to S = 0.

// File: rtl/pswd_pkg.sv
package pswd_pkg;
  localparam int DEF_BASE_MOD = 2;  // prescaler low modulus N
  localparam int DEF_PC_W     = 3;  // program counter modulus 2**PC_W
  localparam int DEF_SW_W     = 3;  // swallow word width

  function automatic int ratio_f(int base_mod, int pc_mod, int s);
    return base_mod * pc_mod + s;
  endfunction
endpackage

// File: rtl/pswd_prescaler.sv
module pswd_prescaler #(
  parameter int BASE_MOD = pswd_pkg::DEF_BASE_MOD
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mod_ctrl_i,
  output logic tick_o
);
  localparam int CW = $clog2(BASE_MOD + 1);
  localparam logic [CW-1:0] LAST_LO = CW'(BASE_MOD - 1);
  localparam logic [CW-1:0] LAST_HI = CW'(BASE_MOD);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last;

  assign last   = mod_ctrl_i ? LAST_LO : LAST_HI;
  assign tick_o = (cnt_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/pswd_swallow.sv
module pswd_swallow #(
  parameter int SW_W = pswd_pkg::DEF_SW_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic            restart_i,
  input  logic [SW_W-1:0] swallow_i,
  output logic            mod_ctrl_o,
  output logic [SW_W-1:0] swallow_q_o
);
  logic [SW_W-1:0] cnt_q;
  logic [SW_W-1:0] s_q;

  // reaching the programmed word freezes the count and holds the output high
  assign mod_ctrl_o  = (cnt_q == s_q);
  assign swallow_q_o = s_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      s_q   <= '0;
    end else if (restart_i) begin
      cnt_q <= '0;
      s_q   <= swallow_i;
    end else if (tick_i && !mod_ctrl_o) begin
      cnt_q <= cnt_q + SW_W'(1);
    end
  end
endmodule

// File: rtl/pswd_progctr.sv
module pswd_progctr #(
  parameter int PC_W = pswd_pkg::DEF_PC_W
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  output logic wrap_o
);
  logic [PC_W-1:0] cnt_q;

  assign wrap_o = tick_i && (&cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + PC_W'(1);  // natural wrap at 2**PC_W
  end
endmodule

// File: rtl/pswd_shaper.sv
module pswd_shaper #(
  parameter int BASE_MOD = pswd_pkg::DEF_BASE_MOD,
  parameter int PC_MOD   = 8,
  parameter int SW_W     = pswd_pkg::DEF_SW_W,
  parameter int POS_W    = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wrap_i,
  input  logic [SW_W-1:0] swallow_q_i,
  output logic            div_clk_o,
  output logic            period_end_o
);
  localparam logic [POS_W-1:0] BASE_RATIO = POS_W'(BASE_MOD * PC_MOD);

  logic [POS_W-1:0] pos_q;
  logic [POS_W-1:0] ratio;
  logic [POS_W-1:0] half;
  logic             pe_q;

  assign ratio        = BASE_RATIO + POS_W'(swallow_q_i);
  assign half         = ratio >> 1;
  assign div_clk_o    = (pos_q < half);
  assign period_end_o = pe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q <= '0;
      pe_q  <= 1'b0;
    end else begin
      pe_q  <= wrap_i;
      pos_q <= wrap_i ? '0 : pos_q + POS_W'(1);
    end
  end
endmodule

// File: rtl/swallow_clk_div.sv
module swallow_clk_div #(
  parameter int BASE_MOD = pswd_pkg::DEF_BASE_MOD,
  parameter int PC_W     = pswd_pkg::DEF_PC_W,
  parameter int SW_W     = pswd_pkg::DEF_SW_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [SW_W-1:0] swallow_i,
  output logic            div_clk_o,
  output logic            mod_ctrl_o,
  output logic            period_end_o
);
  localparam int PC_MOD    = 1 << PC_W;
  localparam int RATIO_MAX = pswd_pkg::ratio_f(BASE_MOD, PC_MOD, (1 << SW_W) - 1);
  localparam int POS_W     = $clog2(RATIO_MAX);

  logic            tick;
  logic            wrap;
  logic            mc;
  logic [SW_W-1:0] swallow_q;

  assign mod_ctrl_o = mc;

  pswd_prescaler #(.BASE_MOD(BASE_MOD)) u_presc (
    .clk_i(clk_i), .rst_ni(rst_ni), .mod_ctrl_i(mc), .tick_o(tick)
  );

  pswd_swallow #(.SW_W(SW_W)) u_swallow (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .restart_i(wrap),
    .swallow_i(swallow_i), .mod_ctrl_o(mc), .swallow_q_o(swallow_q)
  );

  pswd_progctr #(.PC_W(PC_W)) u_prog (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .wrap_o(wrap)
  );

  pswd_shaper #(
    .BASE_MOD(BASE_MOD), .PC_MOD(PC_MOD), .SW_W(SW_W), .POS_W(POS_W)
  ) u_shape (
    .clk_i(clk_i), .rst_ni(rst_ni), .wrap_i(wrap), .swallow_q_i(swallow_q),
    .div_clk_o(div_clk_o), .period_end_o(period_end_o)
  );
endmodule

// File: rtl/pswd_checker.sv
module pswd_checker #(
  parameter int BASE_MOD = pswd_pkg::DEF_BASE_MOD,
  parameter int PC_W     = pswd_pkg::DEF_PC_W,
  parameter int SW_W     = pswd_pkg::DEF_SW_W
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            div_clk_i,
  input logic            mc_i,
  input logic            pe_i,
  input logic [SW_W-1:0] s_q_i
);
  localparam int PC_MOD = 1 << PC_W;
  localparam int GW     = $clog2(pswd_pkg::ratio_f(BASE_MOD, PC_MOD, 1 << SW_W)) + 1;

  logic [GW-1:0]   gap_q;
  logic            seen_q;
  logic [SW_W-1:0] s_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q    <= '0;
      seen_q   <= 1'b0;
      s_prev_q <= '0;
    end else if (pe_i) begin
      gap_q    <= GW'(1);
      seen_q   <= 1'b1;
      s_prev_q <= s_q_i;
    end else if (gap_q != '1) begin
      gap_q <= gap_q + GW'(1);
    end
  end

  AST_PERIOD_RATIO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pe_i && seen_q |-> int'(gap_q) == pswd_pkg::ratio_f(BASE_MOD, PC_MOD, int'(s_prev_q))); // R1
  AST_MC_LOW_AT_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pe_i && (s_q_i != '0) |-> !mc_i); // R3
  AST_MC_HIGH_ZERO_S: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pe_i && (s_q_i == '0) |-> mc_i); // R3
  AST_MC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mc_i |=> (mc_i || pe_i)); // R3
  AST_S_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pe_i |-> $stable(s_q_i)); // R4
  AST_DIV_HIGH_AT_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pe_i |-> div_clk_i); // R5
  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pe_i |=> !pe_i); // R6
endmodule

bind swallow_clk_div pswd_checker #(
  .BASE_MOD(BASE_MOD), .PC_W(PC_W), .SW_W(SW_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .div_clk_i(div_clk_o),
  .mc_i(mod_ctrl_o), .pe_i(period_end_o), .s_q_i(swallow_q)
);

// File: tb/sim_swallow_clk_div.sv
module sim_swallow_clk_div;
  localparam int CLK_PERIOD = 10;
  localparam int BASE_R     = 16;  // 2 * 8
  localparam int PMOD       = 8;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] swallow = 3'd0;
  logic       div_clk, mc, pe;

  int n_tests = 0;
  int n_fail  = 0;
  int exp_q[$];
  bit started = 0;
  bit prev_pe = 0;
  int cnt = 0, hi = 0, mch = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  swallow_clk_div u0 (
    .clk_i(clk), .rst_ni(rst_ni), .swallow_i(swallow),
    .div_clk_o(div_clk), .mod_ctrl_o(mc), .period_end_o(pe)
  );

  task automatic check(bit ok, string req, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: measures each period and compares with the queued expectation
  initial forever begin
    @(negedge clk);
    if (rst_ni) begin
      if (prev_pe) check(!pe, "R6 pulse width", int'(pe), 0);
      if (pe && started) begin
        if (exp_q.size() == 0) check(0, "R1 no expectation queued", cnt, -1);
        else begin
          int e;
          e = exp_q.pop_front();
          check(cnt == e, "R1 period length", cnt, e);
          check(hi == e / 2, "R5 high cycles", hi, e / 2);
          check(mch == 2 * (PMOD - (e - BASE_R)), "R2 R3 divide-by-2 cycles",
                mch, 2 * (PMOD - (e - BASE_R)));
        end
      end
      if (pe) begin
        started = 1; cnt = 0; hi = 0; mch = 0;
      end
      if (started) begin
        cnt++; hi += int'(div_clk); mch += int'(mc);
      end
      prev_pe = pe;
    end else begin
      prev_pe = 0;
    end
  end

  // driver: at every boundary push the ratio of the period that starts there
  task automatic step();
    @(negedge clk);
    if (rst_ni && pe) exp_q.push_back(BASE_R + int'(swallow));
  endtask

  task automatic wait_pulses(int n);
    int k = 0;
    while (k < n) begin
      step();
      if (rst_ni && pe) k++;
    end
  endtask

  task automatic do_reset();
    int n = 0;
    @(negedge clk);
    rst_ni = 1'b0;
    started = 0;
    exp_q.delete();
    repeat (2) @(negedge clk);
    check(div_clk == 1'b1, "R7 div_clk in reset", int'(div_clk), 1);
    check(mc == 1'b1, "R7 mod_ctrl in reset", int'(mc), 1);
    check(pe == 1'b0, "R7 pulse in reset", int'(pe), 0);
    @(posedge clk);
    #1;
    exp_q.push_back(BASE_R);  // first period after release uses S = 0
    cnt = 0; hi = 0; mch = 0;
    started = 1;
    rst_ni = 1'b1;
    forever begin
      step();
      if (pe) break;
      n++;
    end
    check(n == BASE_R, "R7 first period after release", n, BASE_R);
  endtask

  initial begin
    int len;
    swallow = 3'd3;
    do_reset();
    for (int s = 0; s < 8; s++) begin
      swallow = 3'(s);
      wait_pulses(3);
    end

    // mid-period change of S
    swallow = 3'd2;
    wait_pulses(2);
    len = 1;
    repeat (5) begin step(); len++; end
    swallow = 3'd7;
    forever begin
      step();
      if (pe) break;
      len++;
    end
    check(len == BASE_R + 2, "R4 mid-period change ignored", len, BASE_R + 2);
    wait_pulses(2);

    // reset in the middle of a period with nonzero S applied
    swallow = 3'd5;
    wait_pulses(1);
    repeat (7) step();
    do_reset();
    wait_pulses(3);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule